// File: doc/BRIEF.md
# Configuration Image Loader with Signature and Checksum Validation

After reset this block fetches a 64-word, 16-bit configuration image from a simple synchronous word-read memory. It asks for one word at a time and waits for a read-data-valid strobe before asking for the next, so the memory may take a different number of cycles for each read. While the words go by it keeps a running 16-bit sum and captures the few words and fields the configuration needs.

When the last word arrives, the image is accepted only if two conditions hold. The two-bit signature in word 13h must be 10b, and the sum of all 64 words must be BABAh. For an accepted image the block commits a 48-bit station address, the PCI identity values, a PHY type code and two LED control words. For a rejected image it commits built-in defaults. All outputs change in the same cycle as a one-cycle done pulse. After that, software may replace the station address through an override write.

Top module: `nvm_cfg_loader`

## Requirements
- R1: While reset is held and until done rises, `cfg_valid` and `done` are 0 and every configuration output shows its default: station address 0, subsystem ID 0000h, subsystem vendor 8086h, device ID 0100h, vendor ID 8086h, PHY type 00b, LED words 0007h and 0604h.
- R2: On the first clock after reset release, `rd_req` pulses for one cycle at address 0. Each further address (ascending by one up to 3Fh) is requested once, only after `rd_valid` has answered the previous request. Exactly 64 requests are made, and `rd_valid` with no request pending is ignored.
- R3: The image is valid only if the modulo-2^16 sum of words 00h..3Fh, starting from 0000h, equals BABAh.
- R4: The image is valid only if word 13h bits 15:14 equal 10b. The values 00b, 01b and 11b reject it.
- R5: A rejected image leaves `cfg_valid` at 0 and commits the R1 defaults on every output.
- R6: For a valid image, `mac_addr` = {word 02h, word 01h, word 00h}, so address byte 1 is `mac_addr[7:0]` = word 00h bits 7:0.
- R7: For a valid image, word 0Ah bit 1 = 1 loads `subsys_id` from word 0Bh and `subsys_vendor` from word 0Ch. Bit 1 = 0 keeps 0000h and 8086h.
- R8: For a valid image, word 0Ah bit 0 = 1 loads `device_id` from word 0Dh and `vendor_id` from word 0Eh. Bit 0 = 0 keeps 0100h and 8086h.
- R9: For a valid image, `phy_type` = word 13h bits 7:6, `led_word_a` = word 17h and `led_word_b` = word 18h.
- R10: `done` is high for exactly one cycle. The outputs take their committed values in that cycle, and no further read or done pulse follows until the next reset.
- R11: `sw_mac_we` after done replaces `mac_addr` with `sw_mac` one clock later, and the new value is kept until reset. `sw_mac_we` before done has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | One-cycle read request to the image memory |
| rd_addr | output | 6 | Word address of the current request |
| rd_data | input | 16 | Word returned by the memory |
| rd_valid | input | 1 | Strobe marking `rd_data` as the answer |
| sw_mac_we | input | 1 | Software station-address override write |
| sw_mac | input | 48 | Override station address |
| done | output | 1 | One-cycle load-complete pulse |
| cfg_valid | output | 1 | Image passed signature and checksum |
| mac_addr | output | 48 | Station address |
| subsys_id | output | 16 | Subsystem ID |
| subsys_vendor | output | 16 | Subsystem vendor ID |
| device_id | output | 16 | Device ID |
| vendor_id | output | 16 | Vendor ID |
| phy_type | output | 2 | PHY type code |
| led_word_a | output | 16 | LED control word from image word 17h |
| led_word_b | output | 16 | LED control word from image word 18h |

## Verification
The bench uses the default build: 64 words of 16 bits and a BABAh target. That width keeps the full 64-word walk short enough to repeat for every combination of the four signature codes and the four identity-select patterns. Each pass applies its own per-read latency pattern of 1 to 4 cycles. The expected sums are worked out in the bench. Single-count corruptions of the checksum word in both directions check R3. A dedicated pass checks early and late override writes, and stray valid strobes after completion.

// File: rtl/nvm_cfg_pkg.sv
package nvm_cfg_pkg;

  typedef enum logic [1:0] {
    ST_START  = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } ld_state_e;

  // image word offsets that steer behaviour
  localparam int unsigned OFS_CTRL   = 'h0A;
  localparam int unsigned OFS_SHARED = 'h13;

  // staged words, index -> image offset
  localparam int unsigned STAGE_N  = 9;
  localparam int unsigned SI_MAC0  = 0;
  localparam int unsigned SI_MAC1  = 1;
  localparam int unsigned SI_MAC2  = 2;
  localparam int unsigned SI_SSID  = 3;
  localparam int unsigned SI_SSVID = 4;
  localparam int unsigned SI_DID   = 5;
  localparam int unsigned SI_VID   = 6;
  localparam int unsigned SI_LEDA  = 7;
  localparam int unsigned SI_LEDB  = 8;

  function automatic int unsigned stage_ofs(input int unsigned k);
    case (k)
      SI_MAC0:  return 'h00;
      SI_MAC1:  return 'h01;
      SI_MAC2:  return 'h02;
      SI_SSID:  return 'h0B;
      SI_SSVID: return 'h0C;
      SI_DID:   return 'h0D;
      SI_VID:   return 'h0E;
      SI_LEDA:  return 'h17;
      default:  return 'h18;
    endcase
  endfunction

endpackage

// File: rtl/nvm_cfg_seq.sv
module nvm_cfg_seq
  import nvm_cfg_pkg::*;
#(
  parameter int unsigned IMG_WORDS = 64,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              accept,
  output logic              last_word,
  output logic              finished
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(IMG_WORDS - 1);

  ld_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q + 1'b1;
    addr_en = 1'b0;
    case (state_q)
      ST_START: state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid) begin
          if (addr_q == LAST) begin
            state_d = ST_FINISH;
          end else begin
            state_d = ST_ISSUE;
            addr_en = 1'b1;
          end
        end
      end
      ST_FINISH: state_d = ST_FINISH;
      default:   state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign rd_req    = (state_q == ST_ISSUE);
  assign rd_addr   = addr_q;
  assign accept    = (state_q == ST_WAIT) && rd_valid;
  assign last_word = accept && (addr_q == LAST);
  assign finished  = (state_q == ST_FINISH);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);  // R2
  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_word) |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));  // R2
  AST_NO_REQ_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !rd_req);  // R10

endmodule

// File: rtl/nvm_cfg_check.sv
module nvm_cfg_check
  import nvm_cfg_pkg::*;
#(
  parameter int unsigned   ADDR_W     = 6,
  parameter int unsigned   WORD_W     = 16,
  parameter logic [WORD_W-1:0] SUM_TARGET = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              image_ok,
  output logic              sel_subsys,
  output logic              sel_ident,
  output logic [1:0]        phy_code
);

  logic [WORD_W-1:0] sum_q, sum_d;
  logic [1:0]        sig_q;
  logic [1:0]        phy_q;
  logic [1:0]        ctl_q;
  logic              hit_ctrl, hit_shared;

  assign sum_d      = sum_q + rd_data;
  assign hit_ctrl   = accept && (rd_addr == ADDR_W'(OFS_CTRL));
  assign hit_shared = accept && (rd_addr == ADDR_W'(OFS_SHARED));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      sig_q <= '0;
      phy_q <= '0;
      ctl_q <= '0;
    end else begin
      if (accept) sum_q <= sum_d;
      if (hit_shared) begin
        sig_q <= rd_data[WORD_W-1 -: 2];
        phy_q <= rd_data[7:6];
      end
      if (hit_ctrl) ctl_q <= rd_data[1:0];
    end
  end

  // evaluated on the last accepted word, which is included through sum_d
  assign image_ok   = (sum_d == SUM_TARGET) && (sig_q == 2'b10);
  assign sel_subsys = ctl_q[1];
  assign sel_ident  = ctl_q[0];
  assign phy_code   = phy_q;

  AST_SUM_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(sum_q));  // R3

endmodule

// File: rtl/nvm_cfg_stage.sv
module nvm_cfg_stage
  import nvm_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            accept,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic [WORD_W-1:0]               rd_data,
  output logic [STAGE_N-1:0][WORD_W-1:0]  words
);

  for (genvar k = 0; k < STAGE_N; k++) begin : g_slot
    logic [WORD_W-1:0] q;
    logic              hit;
    assign hit = accept && (rd_addr == ADDR_W'(stage_ofs(k)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= rd_data;
    end
    assign words[k] = q;
  end

endmodule

// File: rtl/nvm_cfg_commit.sv
module nvm_cfg_commit
  import nvm_cfg_pkg::*;
#(
  parameter int unsigned   WORD_W    = 16,
  parameter logic [47:0]   DEF_MAC   = 48'h0,
  parameter logic [15:0]   DEF_SSID  = 16'h0000,
  parameter logic [15:0]   DEF_SSVID = 16'h8086,
  parameter logic [15:0]   DEF_DID   = 16'h0100,
  parameter logic [15:0]   DEF_VID   = 16'h8086,
  parameter logic [1:0]    DEF_PHY   = 2'b00,
  parameter logic [15:0]   DEF_LEDA  = 16'h0007,
  parameter logic [15:0]   DEF_LEDB  = 16'h0604
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           last_word,
  input  logic                           finished,
  input  logic                           image_ok,
  input  logic                           sel_subsys,
  input  logic                           sel_ident,
  input  logic [1:0]                     phy_code,
  input  logic [STAGE_N-1:0][WORD_W-1:0] words,
  input  logic                           sw_mac_we,
  input  logic [47:0]                    sw_mac,
  output logic                           done,
  output logic                           cfg_valid,
  output logic [47:0]                    mac_addr,
  output logic [15:0]                    subsys_id,
  output logic [15:0]                    subsys_vendor,
  output logic [15:0]                    device_id,
  output logic [15:0]                    vendor_id,
  output logic [1:0]                     phy_type,
  output logic [15:0]                    led_word_a,
  output logic [15:0]                    led_word_b
);

  logic        mac_en;
  logic [47:0] mac_d;
  logic [15:0] ssid_d, ssvid_d, did_d, vid_d, leda_d, ledb_d;
  logic [1:0]  phy_d;

  always_comb begin
    ssid_d  = DEF_SSID;
    ssvid_d = DEF_SSVID;
    did_d   = DEF_DID;
    vid_d   = DEF_VID;
    phy_d   = DEF_PHY;
    leda_d  = DEF_LEDA;
    ledb_d  = DEF_LEDB;
    mac_d   = DEF_MAC;
    if (image_ok) begin
      mac_d  = {words[SI_MAC2], words[SI_MAC1], words[SI_MAC0]};
      phy_d  = phy_code;
      leda_d = words[SI_LEDA];
      ledb_d = words[SI_LEDB];
      if (sel_subsys) begin
        ssid_d  = words[SI_SSID];
        ssvid_d = words[SI_SSVID];
      end
      if (sel_ident) begin
        did_d = words[SI_DID];
        vid_d = words[SI_VID];
      end
    end
    if (finished) mac_d = sw_mac;
    mac_en = last_word || (finished && sw_mac_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done          <= 1'b0;
      cfg_valid     <= 1'b0;
      mac_addr      <= DEF_MAC;
      subsys_id     <= DEF_SSID;
      subsys_vendor <= DEF_SSVID;
      device_id     <= DEF_DID;
      vendor_id     <= DEF_VID;
      phy_type      <= DEF_PHY;
      led_word_a    <= DEF_LEDA;
      led_word_b    <= DEF_LEDB;
    end else begin
      done <= last_word;
      if (mac_en) mac_addr <= mac_d;
      if (last_word) begin
        cfg_valid     <= image_ok;
        subsys_id     <= ssid_d;
        subsys_vendor <= ssvid_d;
        device_id     <= did_d;
        vendor_id     <= vid_d;
        phy_type      <= phy_d;
        led_word_a    <= leda_d;
        led_word_b    <= ledb_d;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
  AST_HOLD_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !finished |-> (!cfg_valid && mac_addr == DEF_MAC && device_id == DEF_DID));  // R1
  AST_VALID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !done) |=> $stable(cfg_valid) && $stable(device_id));  // R10
  AST_REJECT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_valid) |-> (mac_addr == DEF_MAC && subsys_vendor == DEF_SSVID));  // R5

endmodule

// File: rtl/nvm_cfg_loader.sv
module nvm_cfg_loader
  import nvm_cfg_pkg::*;
#(
  parameter int unsigned IMG_WORDS  = 64,
  parameter int unsigned WORD_W     = 16,
  parameter logic [15:0] SUM_TARGET = 16'hBABA,
  parameter logic [47:0] DEF_MAC    = 48'h0,
  parameter logic [15:0] DEF_SSID   = 16'h0000,
  parameter logic [15:0] DEF_SSVID  = 16'h8086,
  parameter logic [15:0] DEF_DID    = 16'h0100,
  parameter logic [15:0] DEF_VID    = 16'h8086,
  parameter logic [1:0]  DEF_PHY    = 2'b00,
  parameter logic [15:0] DEF_LEDA   = 16'h0007,
  parameter logic [15:0] DEF_LEDB   = 16'h0604
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        rd_req,
  output logic [5:0]  rd_addr,
  input  logic [15:0] rd_data,
  input  logic        rd_valid,
  input  logic        sw_mac_we,
  input  logic [47:0] sw_mac,
  output logic        done,
  output logic        cfg_valid,
  output logic [47:0] mac_addr,
  output logic [15:0] subsys_id,
  output logic [15:0] subsys_vendor,
  output logic [15:0] device_id,
  output logic [15:0] vendor_id,
  output logic [1:0]  phy_type,
  output logic [15:0] led_word_a,
  output logic [15:0] led_word_b
);

  localparam int unsigned ADDR_W = $clog2(IMG_WORDS);

  logic                           accept, last_word, finished;
  logic                           image_ok, sel_subsys, sel_ident;
  logic [1:0]                     phy_code;
  logic [STAGE_N-1:0][WORD_W-1:0] words;

  nvm_cfg_seq #(.IMG_WORDS(IMG_WORDS), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_req(rd_req),
    .rd_addr(rd_addr), .accept(accept), .last_word(last_word), .finished(finished)
  );

  nvm_cfg_check #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SUM_TARGET(SUM_TARGET)) u_check (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rd_addr(rd_addr), .rd_data(rd_data),
    .image_ok(image_ok), .sel_subsys(sel_subsys), .sel_ident(sel_ident), .phy_code(phy_code)
  );

  nvm_cfg_stage #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rd_addr(rd_addr), .rd_data(rd_data),
    .words(words)
  );

  nvm_cfg_commit #(
    .WORD_W(WORD_W), .DEF_MAC(DEF_MAC), .DEF_SSID(DEF_SSID), .DEF_SSVID(DEF_SSVID),
    .DEF_DID(DEF_DID), .DEF_VID(DEF_VID), .DEF_PHY(DEF_PHY),
    .DEF_LEDA(DEF_LEDA), .DEF_LEDB(DEF_LEDB)
  ) u_commit (
    .clk(clk), .rst_n(rst_n), .last_word(last_word), .finished(finished),
    .image_ok(image_ok), .sel_subsys(sel_subsys), .sel_ident(sel_ident),
    .phy_code(phy_code), .words(words), .sw_mac_we(sw_mac_we), .sw_mac(sw_mac),
    .done(done), .cfg_valid(cfg_valid), .mac_addr(mac_addr), .subsys_id(subsys_id),
    .subsys_vendor(subsys_vendor), .device_id(device_id), .vendor_id(vendor_id),
    .phy_type(phy_type), .led_word_a(led_word_a), .led_word_b(led_word_b)
  );

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> finished);  // R10
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !accept) |=> $stable(rd_addr));  // R2

endmodule

// File: tb/nvm_cfg_loader_bench.sv
`timescale 1ns/1ps
module nvm_cfg_loader_bench;

  logic        clk;
  logic        rst_n;
  logic        rd_req;
  logic [5:0]  rd_addr;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        sw_mac_we;
  logic [47:0] sw_mac;
  logic        done, cfg_valid;
  logic [47:0] mac_addr;
  logic [15:0] subsys_id, subsys_vendor, device_id, vendor_id, led_word_a, led_word_b;
  logic [1:0]  phy_type;

  // bench-side copies of the defaults in R1
  localparam logic [15:0] E_SSID = 16'h0000, E_SSVID = 16'h8086;
  localparam logic [15:0] E_DID  = 16'h0100, E_VID   = 16'h8086;
  localparam logic [15:0] E_LEDA = 16'h0007, E_LEDB  = 16'h0604;

  logic [15:0] img [64];
  int checks, errors, cyc;
  int lat_mode, reqs, addr_err, exp_addr, pend, cnt, paddr;
  bit spur;

  nvm_cfg_loader u_nvm_cfg_loader (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .sw_mac_we(sw_mac_we), .sw_mac(sw_mac), .done(done),
    .cfg_valid(cfg_valid), .mac_addr(mac_addr), .subsys_id(subsys_id),
    .subsys_vendor(subsys_vendor), .device_id(device_id), .vendor_id(vendor_id),
    .phy_type(phy_type), .led_word_a(led_word_a), .led_word_b(led_word_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // memory model: answers each request after a variable delay
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0; rd_valid = 1'b0; rd_data = '0;
    end else begin
      rd_valid = 1'b0;
      if (pend != 0) begin
        if (cnt == 0) begin
          rd_valid = 1'b1; rd_data = img[paddr]; pend = 0;
        end else cnt--;
      end else if (rd_req) begin
        if (int'(rd_addr) != exp_addr) addr_err++;
        exp_addr++; reqs++;
        pend = 1; paddr = int'(rd_addr); cnt = (int'(rd_addr) + lat_mode) % 4;
      end else if (spur) begin
        rd_valid = 1'b1; rd_data = 16'hDEAD;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // builds an image, loads it, checks every output at the done cycle
  task automatic run_case(input int sig, input int ctrl, input int corrupt,
                          input int seed, input bit early_ovr);
    logic [15:0] s;
    bit   ok, hold_ok;
    int   n;
    for (int i = 0; i < 63; i++) img[i] = 16'(i * 16'h1357 + seed * 16'h0F0F) ^ 16'hA5A5;
    img['h0A] = {img['h0A][15:2], 2'(ctrl)};
    img['h13] = {2'(sig), img['h13][13:8], 2'(seed), img['h13][5:0]};
    s = '0;
    for (int i = 0; i < 63; i++) s = s + img[i];
    img[63] = 16'hBABA - s;
    if (corrupt > 0) img[63] = img[63] + 16'd1;
    if (corrupt < 0) img[63] = img[63] - 16'd1;
    ok = (sig == 2) && (corrupt == 0);

    lat_mode = seed; reqs = 0; addr_err = 0; exp_addr = 0;
    do_reset();
    chk("R1", "reset valid/done/req", {61'b0, cfg_valid, done, rd_req}, 64'd0);
    chk("R1", "reset mac", mac_addr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "first request addr0", {57'b0, rd_req, rd_addr}, {57'b0, 1'b1, 6'd0});
    n = 0; hold_ok = 1;
    while (!done && n < 3000) begin
      if (cfg_valid || mac_addr != 48'h0 || device_id != E_DID || led_word_a != E_LEDA)
        hold_ok = 0;
      sw_mac_we = early_ovr && (n == 40);
      sw_mac    = 48'h1122_3344_5566;
      @(negedge clk);
      n++;
    end
    sw_mac_we = 1'b0;
    chk("R10", "done seen", {63'b0, done}, 64'd1);
    chk("R1", "defaults held until done", {63'b0, hold_ok}, 64'd1);
    chk("R2", "64 ordered requests", {32'(reqs), 32'(addr_err)}, {32'd64, 32'd0});
    chk(ok ? "R3" : (sig != 2 ? "R4" : "R3"), "cfg_valid", {63'b0, cfg_valid}, {63'b0, ok});
    if (ok) begin
      chk("R6", "mac", mac_addr, {img[2], img[1], img[0]});
      chk("R7", "subsys", {subsys_id, subsys_vendor},
          (ctrl & 2) ? {img['h0B], img['h0C]} : {E_SSID, E_SSVID});
      chk("R8", "ident", {device_id, vendor_id},
          (ctrl & 1) ? {img['h0D], img['h0E]} : {E_DID, E_VID});
      chk("R9", "phy/leds", {phy_type, led_word_a, led_word_b},
          {img['h13][7:6], img['h17], img['h18]});
    end else begin
      chk("R5", "mac default", mac_addr, 64'd0);
      chk("R5", "ids default", {subsys_id, subsys_vendor, device_id, vendor_id},
          {E_SSID, E_SSVID, E_DID, E_VID});
      chk("R5", "phy/leds default", {phy_type, led_word_a, led_word_b},
          {2'b00, E_LEDA, E_LEDB});
    end
    @(negedge clk);
    chk("R10", "done one cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    checks = 0; errors = 0; spur = 0; lat_mode = 0;
    sw_mac_we = 1'b0; sw_mac = '0; rst_n = 1'b0;
    for (int i = 0; i < 64; i++) img[i] = '0;

    // R4 R7 R8: every signature code against every select pattern
    for (int sg = 0; sg < 4; sg++)
      for (int ct = 0; ct < 4; ct++)
        run_case(sg, ct, 0, sg * 4 + ct, 1'b0);

    // R3: checksum off by one in both directions
    run_case(2, 3, 1, 7, 1'b0);
    run_case(2, 3, -1, 9, 1'b0);

    // R11: early override ignored, late override wins
    run_case(2, 3, 0, 5, 1'b1);
    sw_mac = 48'hA1B2_C3D4_E5F6; sw_mac_we = 1'b1;
    @(negedge clk);
    sw_mac_we = 1'b0;
    chk("R11", "override applied", mac_addr, 64'hA1B2_C3D4_E5F6);
    chk("R11", "valid kept", {63'b0, cfg_valid}, 64'd1);
    // R10 R2: stray strobes after completion cause nothing
    spur = 1;
    begin
      bit quiet = 1;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done || rd_req) quiet = 0;
      end
      chk("R10", "no activity after done", {63'b0, quiet}, 64'd1);
    end
    spur = 0;
    chk("R11", "override persists", mac_addr, 64'hA1B2_C3D4_E5F6);
    do_reset();
    chk("R11", "override cleared by reset", mac_addr, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule